// File: doc/BRIEF.md
# Virtual Screen Geometry Calculator

This block works out the memory layout of a panned virtual screen held in video memory. Software sets the visible mode (horizontal and vertical resolution, colour depth) on input ports. It then writes a virtual width, and the block derives the scanline pitch in bytes and the number of whole scanlines that fit in a memory of fixed size. The width is taken only when both the width and the derived height cover the visible mode.

The height needs a division of the memory size by the pitch. A sequential restoring divider does this over several cycles. `busy` is high while the divider runs. A one-cycle `done` pulse then returns the accept or reject verdict.

Writes of the horizontal and vertical pan offsets are stored. Each one recomputes the display start address from the pitch and the pixel offsets, expressed in 32-bit words.

Top module: `vscreen_geom`

## Requirements
- R1: After reset, virt_width, virt_height, line_offset and start_addr are zero, and busy, done and vw_accept are low.
- R2: A virtual-width write with a value below xres is rejected. done pulses with vw_accept low, and no output state changes.
- R3: The pitch is width/2 (integer) when bpp equals 4. For any other bpp it is width * floor((bpp+7)/8). bpp is a plain binary bit count (4, 8, 15, 16, 24 or 32).
- R4: The candidate height is floor(MEM_BYTES / pitch). If it is below yres, the write is rejected with vw_accept low and no state changes.
- R5: An accepted write updates virt_width, virt_height and line_offset together, in the same cycle as a one-cycle done pulse with vw_accept high. done is never high while busy is high.
- R6: busy rises only after a virtual-width write and stays high until done. A virtual-width write that arrives while busy is high is ignored: it does not alter the result and produces no extra done pulse.
- R7: A candidate pitch of zero is rejected, and no state changes.
- R8: A write to xoff or yoff stores that offset. On the next cycle start_addr equals (line_offset*Y + Xbytes) >> 2. Xbytes is X/2 when bpp is 4, and X*floor((bpp+7)/8) otherwise.
- R9: start_addr changes only on offset writes. A later accepted width write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xres | input | DIM_W | Current horizontal resolution in pixels |
| yres | input | DIM_W | Current vertical resolution in lines |
| bpp | input | 6 | Bits per pixel, binary |
| vw_wr | input | 1 | Virtual-width write strobe |
| vw_data | input | DIM_W | Virtual width in pixels |
| xoff_wr | input | 1 | Horizontal offset write strobe |
| xoff_data | input | DIM_W | Horizontal offset in pixels |
| yoff_wr | input | 1 | Vertical offset write strobe |
| yoff_data | input | DIM_W | Vertical offset in lines |
| busy | output | 1 | Height division in progress |
| done | output | 1 | One-cycle completion pulse of a width write |
| vw_accept | output | 1 | Verdict of the width write, valid with done |
| line_offset | output | DIM_W+3 | Scanline pitch in bytes |
| virt_width | output | DIM_W | Accepted virtual width |
| virt_height | output | MEM_W | Virtual height in scanlines |
| start_addr | output | ADDR_W | Display start address in 32-bit words |

## Verification
Width writes are swept on a small memory across every supported colour depth. The widths run from zero through values below the horizontal resolution up to pitches too large for the visible height. This separates the three reject reasons from acceptance and exposes pitch errors that are specific to one depth. A 4-bit depth with a width of one produces a zero pitch. A second write issued while busy shows whether the divider can be restarted. Offset pairs are swept after each accepted width, with X values that are odd and not word-aligned, so that halving at 4 bits and dropping the two low bits are both visible in the start address.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   // colour depth code for which two pixels share one byte
   localparam logic [5:0] NIBBLE_BPP = 6'd4;

   function automatic logic [2:0] bytes_per_pixel(input logic [5:0] depth);
      logic [6:0] sum;
      sum = {1'b0, depth} + 7'd7;
      return sum[5:3];
   endfunction
endpackage

// File: rtl/vsg_pitch.sv
module vsg_pitch #(
   parameter int IN_W = 16,
   localparam int OUT_W = IN_W + 3
) (
   input  logic [IN_W-1:0]  count,
   input  logic [5:0]       depth,
   output logic [OUT_W-1:0] nbytes
);
   import vsg_pkg::*;

   always_comb begin
      if (depth == NIBBLE_BPP)
         nbytes = OUT_W'(count >> 1);
      else
         nbytes = OUT_W'(count) * OUT_W'(bytes_per_pixel(depth));
   end
endmodule

// File: rtl/vsg_divider.sv
module vsg_divider #(
   parameter int NUM_W = 13,
   parameter int DEN_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] numer,
   input  logic [DEN_W-1:0] denom,
   output logic             fin,
   output logic [NUM_W-1:0] quot
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] den_q;
   logic [DEN_W-1:0] rem_q;
   logic [NUM_W-1:0] quo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [DEN_W:0]   rem_sh;
   logic [DEN_W:0]   diff;

   generate
      if (NUM_W < 2) begin : g_bad_num
         $error("vsg_divider: NUM_W must be at least 2");
      end
   endgenerate

   always_comb begin
      rem_sh = {rem_q, quo_q[NUM_W-1]};
      diff   = rem_sh - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         den_q <= '0;
         rem_q <= '0;
         quo_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            den_q <= denom;
            rem_q <= '0;
            quo_q <= numer;
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (!diff[DEN_W]) begin
               rem_q <= diff[DEN_W-1:0];
               quo_q <= {quo_q[NUM_W-2:0], 1'b1};
            end else begin
               rem_q <= rem_sh[DEN_W-1:0];
               quo_q <= {quo_q[NUM_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end

   assign quot = quo_q;

   // R4
   quotient_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> ((NUM_W + DEN_W)'(quot) * (NUM_W + DEN_W)'(den_q) <= (NUM_W + DEN_W)'(numer)));

   // R5
   fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
endmodule

// File: rtl/vscreen_geom.sv
module vscreen_geom #(
   parameter int DIM_W     = 16,
   parameter int MEM_BYTES = 1 << 20,
   parameter int ADDR_W    = 32,
   localparam int LO_W     = DIM_W + 3,
   localparam int MEM_W    = $clog2(MEM_BYTES + 1),
   localparam int SUM_W    = LO_W + DIM_W + 1,
   localparam int CMP_W    = (MEM_W > DIM_W) ? MEM_W : DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIM_W-1:0]  xres,
   input  logic [DIM_W-1:0]  yres,
   input  logic [5:0]        bpp,
   input  logic              vw_wr,
   input  logic [DIM_W-1:0]  vw_data,
   input  logic              xoff_wr,
   input  logic [DIM_W-1:0]  xoff_data,
   input  logic              yoff_wr,
   input  logic [DIM_W-1:0]  yoff_data,
   output logic              busy,
   output logic              done,
   output logic              vw_accept,
   output logic [LO_W-1:0]   line_offset,
   output logic [DIM_W-1:0]  virt_width,
   output logic [MEM_W-1:0]  virt_height,
   output logic [ADDR_W-1:0] start_addr
);
   generate
      if (MEM_BYTES < 2) begin : g_bad_mem
         $error("vscreen_geom: MEM_BYTES must be at least 2");
      end
      if (DIM_W < 4) begin : g_bad_dim
         $error("vscreen_geom: DIM_W must be at least 4");
      end
   endgenerate

   // pitch units: index 0 sizes the candidate width, index 1 the X offset
   logic [DIM_W-1:0] pitch_in  [2];
   logic [LO_W-1:0]  pitch_out [2];
   logic [DIM_W-1:0] x_next, y_next;

   assign x_next      = xoff_wr ? xoff_data : xo_q;
   assign y_next      = yoff_wr ? yoff_data : yo_q;
   assign pitch_in[0] = vw_data;
   assign pitch_in[1] = x_next;

   genvar gi;
   generate
      for (gi = 0; gi < 2; gi++) begin : g_pitch
         vsg_pitch #(.IN_W(DIM_W)) pitch_i (
            .count (pitch_in[gi]),
            .depth (bpp),
            .nbytes(pitch_out[gi])
         );
      end
   endgenerate

   logic [DIM_W-1:0] xo_q, yo_q;
   logic [DIM_W-1:0] pend_w_q, yres_q;
   logic [LO_W-1:0]  pend_lo_q;
   logic             start_ok, quick_rej, div_fin, fits;
   logic [MEM_W-1:0] quot;
   logic [SUM_W-1:0] sum;

   assign start_ok  = vw_wr && !busy;
   assign quick_rej = (vw_data < xres) || (pitch_out[0] == '0);
   assign fits      = CMP_W'(quot) >= CMP_W'(yres_q);
   assign sum       = SUM_W'(line_offset) * SUM_W'(y_next) + SUM_W'(pitch_out[1]);

   vsg_divider #(.NUM_W(MEM_W), .DEN_W(LO_W)) div_i (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start_ok && !quick_rej),
      .numer(MEM_W'(MEM_BYTES)),
      .denom(pitch_out[0]),
      .fin  (div_fin),
      .quot (quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         done        <= 1'b0;
         vw_accept   <= 1'b0;
         line_offset <= '0;
         virt_width  <= '0;
         virt_height <= '0;
         pend_w_q    <= '0;
         pend_lo_q   <= '0;
         yres_q      <= '0;
      end else begin
         done      <= 1'b0;
         vw_accept <= 1'b0;
         if (start_ok) begin
            if (quick_rej) begin
               done <= 1'b1;
            end else begin
               busy      <= 1'b1;
               pend_w_q  <= vw_data;
               pend_lo_q <= pitch_out[0];
               yres_q    <= yres;
            end
         end
         if (div_fin) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            vw_accept <= fits;
            if (fits) begin
               virt_width  <= pend_w_q;
               line_offset <= pend_lo_q;
               virt_height <= quot;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xo_q       <= '0;
         yo_q       <= '0;
         start_addr <= '0;
      end else if (xoff_wr || yoff_wr) begin
         xo_q       <= x_next;
         yo_q       <= y_next;
         start_addr <= ADDR_W'(sum >> 2);
      end
   end

   // R5
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vw_accept |-> done);

   // R6
   start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(vw_wr));

   // R2
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(virt_width) |-> (done && vw_accept));

   // R7
   pitch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && vw_accept) |-> (line_offset != '0));

   // R9
   start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(start_addr) |-> ($past(xoff_wr) || $past(yoff_wr)));
endmodule

// File: tb/vscreen_geom_tb.sv
module vscreen_geom_tb_top;
   localparam int DIM_W  = 16;
   localparam int MEMB   = 4096;
   localparam int ADDR_W = 32;
   localparam int LO_W   = DIM_W + 3;
   localparam int MEM_W  = $clog2(MEMB + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DIM_W-1:0]  xres = '0, yres = '0;
   logic [5:0]        bpp = 6'd8;
   logic              vw_wr = 1'b0, xoff_wr = 1'b0, yoff_wr = 1'b0;
   logic [DIM_W-1:0]  vw_data = '0, xoff_data = '0, yoff_data = '0;
   logic              busy, done, vw_accept;
   logic [LO_W-1:0]   line_offset;
   logic [DIM_W-1:0]  virt_width;
   logic [MEM_W-1:0]  virt_height;
   logic [ADDR_W-1:0] start_addr;

   int checks = 0, fails = 0;
   int m_w = 0, m_h = 0, m_lo = 0, m_x = 0, m_y = 0, m_sa = 0;

   always #5 clk = ~clk;

   vscreen_geom #(.DIM_W(DIM_W), .MEM_BYTES(MEMB), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .xres(xres), .yres(yres), .bpp(bpp),
      .vw_wr(vw_wr), .vw_data(vw_data), .xoff_wr(xoff_wr), .xoff_data(xoff_data),
      .yoff_wr(yoff_wr), .yoff_data(yoff_data), .busy(busy), .done(done),
      .vw_accept(vw_accept), .line_offset(line_offset), .virt_width(virt_width),
      .virt_height(virt_height), .start_addr(start_addr));

   function automatic int pix_bytes(int n, int d);
      if (d == 4) return n / 2;
      return n * ((d + 7) / 8);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(string req);
      check(req, int'(virt_width), m_w);
      check(req, int'(virt_height), m_h);
      check(req, int'(line_offset), m_lo);
      check(req, int'(start_addr), m_sa);
   endtask

   task automatic wait_done(output bit acc);
      int n = 0;
      while (!done && n < 100) begin
         @(negedge clk);
         n++;
      end
      if (!done) check("R6 done timeout", 0, 1);
      acc = vw_accept;
   endtask

   task automatic write_width(int w, string req);
      int lo, h;
      bit exp_acc, acc;
      lo = pix_bytes(w, int'(bpp));
      h  = (lo == 0) ? 0 : MEMB / lo;
      exp_acc = (w >= int'(xres)) && (lo != 0) && (h >= int'(yres));
      @(negedge clk);
      vw_wr = 1'b1; vw_data = DIM_W'(w);
      @(negedge clk);
      vw_wr = 1'b0;
      wait_done(acc);
      check(req, int'(acc), int'(exp_acc));
      if (exp_acc) begin
         m_w = w; m_h = h; m_lo = lo;
      end
      check_state(req);
   endtask

   task automatic write_off(bit is_x, int v);
      @(negedge clk);
      if (is_x) begin xoff_wr = 1'b1; xoff_data = DIM_W'(v); m_x = v; end
      else      begin yoff_wr = 1'b1; yoff_data = DIM_W'(v); m_y = v; end
      @(negedge clk);
      xoff_wr = 1'b0; yoff_wr = 1'b0;
      m_sa = (m_lo * m_y + pix_bytes(m_x, int'(bpp))) >> 2;
      check("R8 start address", int'(start_addr), m_sa);
   endtask

   initial begin
      #2000000;
      check("watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int depths [6] = '{4, 8, 15, 16, 24, 32};
      int xs [4] = '{3, 17, 0, 63};
      int ys [4] = '{5, 1, 9, 0};
      bit acc;
      repeat (3) @(negedge clk);
      // R1 reset values
      check_state("R1 reset");
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      rst_n = 1'b1;
      xres = 16'd64; yres = 16'd16;
      // R2 R3 R4 R5 width sweep per depth, with offset sweep (R8)
      foreach (depths[d]) begin
         bpp = 6'(depths[d]);
         for (int w = 0; w <= 320; w += 16) write_width(w, "R2/R3/R4/R5 width sweep");
         write_width(136, "R3 odd-multiple width");
         for (int k = 0; k < 4; k++) begin
            write_off(1'b1, xs[k]);
            write_off(1'b0, ys[k]);
         end
         // R9 an accepted width leaves start address alone
         write_width(200, "R9 start address kept");
      end
      // R7 zero pitch
      xres = '0; bpp = 6'd4;
      write_width(1, "R7 zero pitch");
      write_width(0, "R7 zero width");
      // R6 write during busy ignored
      xres = 16'd64; yres = 16'd16; bpp = 6'd8;
      @(negedge clk);
      vw_wr = 1'b1; vw_data = 16'd128;
      @(negedge clk);
      vw_data = 16'd96;
      check("R6 busy high", int'(busy), 1);
      @(negedge clk);
      vw_wr = 1'b0;
      wait_done(acc);
      check("R6 accept", int'(acc), 1);
      m_w = 128; m_lo = 128; m_h = MEMB / 128;
      check_state("R6 ignored busy write");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (i > 0) check("R6 no extra done", int'(done), 0);
      end
      check_state("R6 state after idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule